// File: doc/BRIEF.md
# JTAG Debug Port Scan Target

This block holds the data-register side of a JTAG debug port. A TAP controller outside the block supplies the current 4-bit instruction and the capture, shift and update strobes. The block decodes the debug instructions and owns a 35-bit access register. Each scan of that register returns a 3-bit acknowledge and the result posted by the previous request. When the scan ends, the block launches a new debug-port or access-port request on a simple register bus that uses a valid/acknowledge handshake.

Reads are posted. The data captured in a scan belongs to the operation that finished before it, so software collects the result of a read with a later scan. A scan that arrives while a request is still outstanding is answered WAIT and leaves the bus untouched. Two sticky flags record faults: overrun, which a WAIT sets when overrun detection is on, and bus error. While the bus-error flag is set, access-port requests are discarded. An abort scan cancels an outstanding request and can clear either flag.

Top module: `dbg_scan_port`

## Requirements
- R1: After reset, `bus_valid`, `ap_abort`, `sticky_err` and `sticky_orun` are all 0.
- R2: Instruction 0xE captures the `ID_VALUE` parameter and shifts it out on `tdo` least-significant bit first over 32 shifts. It launches no bus request.
- R3: An update under instruction 0xA (debug port) or 0xB (access port) that follows an OK capture launches a request. The request is visible the cycle after the update. Shifted bit 0 = 1 means read, so `bus_write` is its inverse. Bits 2:1 drive `bus_addr`, bits 34:3 drive `bus_wdata`, and `bus_ap` is 1 only for 0xB. The request holds steady until `bus_ack`.
- R4: A capture under 0xA, 0xB or 0x8 loads the acknowledge into shifted bits 2:0. The code is 3'b010 (OK/FAULT) when no request is outstanding and 3'b001 (WAIT) while one is outstanding.
- R5: Shifted bits 34:3 of a capture hold the `bus_rdata` that came back with the most recent completed read.
- R6: A scan answered WAIT launches no request, and its write data is discarded: the outstanding request's fields stay unchanged.
- R7: A WAIT capture sets `sticky_orun` only when `orun_detect` is 1.
- R8: `bus_ack` with `bus_err` sets `sticky_err`. While it is set, an access-port (0xB) request is dropped and a debug-port (0xA) request is still launched.
- R9: An update under 0x8 with data bit 0 (shifted bit 3) equal to 1 drops `bus_valid` and pulses `ap_abort` for one cycle. With that bit 0, the outstanding request stays.
- R10: An update under 0x8 with data bit 1 (shifted bit 4) set clears `sticky_err`. Data bit 2 (shifted bit 5) clears `sticky_orun`.
- R11: Any other instruction selects a 1-bit bypass register that captures 0. `tdo` then gives back `tdi` delayed by one shift, and no request is launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| ir | input | 4 | Current instruction from the TAP controller |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift enable |
| update_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the selected register |
| orun_detect | input | 1 | Enables overrun detection |
| bus_valid | output | 1 | Request outstanding |
| bus_ap | output | 1 | 1 = access port, 0 = debug port |
| bus_write | output | 1 | 1 = write |
| bus_addr | output | 2 | Register address bits |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Request completed |
| bus_err | input | 1 | Completion carried an error |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| ap_abort | output | 1 | One-cycle abort pulse |
| sticky_err | output | 1 | Sticky bus-error flag |
| sticky_orun | output | 1 | Sticky overrun flag |

## Verification
A busy flag that never clears shows up as WAIT codes in every later capture, and no further request reaches the bus after the first one. A stale posted register shows up in the data field of the next capture. A launch gate that ignores the WAIT outcome would change the bus fields in the cycle right after the update. Each of these faults appears within one scan, so the bench compares every capture and every bus request against a queue of expected values.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
    localparam int IR_W   = 4;
    localparam int ACK_W  = 3;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 32;
    localparam int ACC_W  = ACK_W + DATA_W;

    localparam logic [IR_W-1:0] IR_ABORT  = 4'h8;
    localparam logic [IR_W-1:0] IR_DPACC  = 4'hA;
    localparam logic [IR_W-1:0] IR_APACC  = 4'hB;
    localparam logic [IR_W-1:0] IR_IDCODE = 4'hE;

    localparam logic [ACK_W-1:0] ACK_OK   = 3'b010;
    localparam logic [ACK_W-1:0] ACK_WAIT = 3'b001;

    // Positions inside the 35-bit access register
    localparam int POS_RNW     = 0;
    localparam int POS_ADDR_LO = 1;
    localparam int POS_DATA_LO = ACK_W;

    typedef enum logic [2:0] {
        K_ABORT, K_DPACC, K_APACC, K_IDCODE, K_BYPASS
    } scan_kind_e;

    typedef struct packed {
        logic              ap;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic scan_kind_e decode_ir(input logic [IR_W-1:0] code);
        case (code)
            IR_ABORT:  return K_ABORT;
            IR_DPACC:  return K_DPACC;
            IR_APACC:  return K_APACC;
            IR_IDCODE: return K_IDCODE;
            default:   return K_BYPASS;
        endcase
    endfunction

    function automatic logic is_access(input scan_kind_e k);
        return (k == K_DPACC) || (k == K_APACC);
    endfunction

    // Insertion point of tdi during a shift, one below the register length
    function automatic int top_bit(input scan_kind_e k);
        case (k)
            K_IDCODE: return DATA_W - 1;
            K_BYPASS: return 0;
            default:  return ACC_W - 1;
        endcase
    endfunction
endpackage

// File: rtl/dbg_scan_shreg.sv
module dbg_scan_shreg
    import dbg_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             shift,
    input  scan_kind_e       kind,
    input  logic [ACC_W-1:0] cap_val,
    input  logic             tdi,
    output logic [ACC_W-1:0] sr
);
    logic [ACC_W-1:0] shifted;

    always_comb begin
        shifted = sr >> 1;
        shifted[top_bit(kind)] = tdi;
    end

    always_ff @(posedge clk) begin
        if (rst)          sr <= '0;
        else if (capture) sr <= cap_val;
        else if (shift)   sr <= shifted;
    end
endmodule

// File: rtl/dbg_scan_req.sv
module dbg_scan_req
    import dbg_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  scan_kind_e        kind,
    input  logic              capture,
    input  logic              update,
    input  logic [ACC_W-1:0]  sr,
    input  logic              orun_detect,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output bus_req_t          req,
    output logic [DATA_W-1:0] posted,
    output logic              abort_pulse,
    output logic              sticky_err,
    output logic              sticky_orun
);
    logic     waited;
    logic     done;
    logic     launch;
    logic     abort_now;
    logic     clr_err;
    logic     clr_orun;
    bus_req_t next_req;

    assign done      = busy && bus_ack;
    assign abort_now = update && (kind == K_ABORT) && sr[POS_DATA_LO];
    assign clr_err   = update && (kind == K_ABORT) && sr[POS_DATA_LO + 1];
    assign clr_orun  = update && (kind == K_ABORT) && sr[POS_DATA_LO + 2];
    assign launch    = update && is_access(kind) && !waited && !busy
                       && !((kind == K_APACC) && sticky_err);

    always_comb begin
        next_req.ap    = (kind == K_APACC);
        next_req.write = !sr[POS_RNW];
        next_req.addr  = sr[POS_ADDR_LO +: ADDR_W];
        next_req.data  = sr[POS_DATA_LO +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= 1'b0;
            req         <= '0;
            posted      <= '0;
            waited      <= 1'b0;
            abort_pulse <= 1'b0;
            sticky_err  <= 1'b0;
            sticky_orun <= 1'b0;
        end else begin
            abort_pulse <= abort_now;
            if (capture && is_access(kind)) waited <= busy;

            if (abort_now)   busy <= 1'b0;
            else if (done)   busy <= 1'b0;
            else if (launch) busy <= 1'b1;

            if (launch) req <= next_req;
            if (done && !req.write) posted <= bus_rdata;

            if (done && bus_err) sticky_err <= 1'b1;
            else if (clr_err)    sticky_err <= 1'b0;

            if (capture && is_access(kind) && busy && orun_detect)
                sticky_orun <= 1'b1;
            else if (clr_orun)
                sticky_orun <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_scan_port.sv
module dbg_scan_port
    import dbg_scan_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h4A5C_3E01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IR_W-1:0]   ir,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    input  logic              orun_detect,
    output logic              bus_valid,
    output logic              bus_ap,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              ap_abort,
    output logic              sticky_err,
    output logic              sticky_orun
);
    scan_kind_e        kind;
    logic [ACC_W-1:0]  sr;
    logic [ACC_W-1:0]  cap_val;
    logic [DATA_W-1:0] posted;
    logic              busy;
    bus_req_t          req;

    assign kind = decode_ir(ir);

    always_comb begin
        case (kind)
            K_IDCODE: cap_val = {{ACK_W{1'b0}}, ID_VALUE};
            K_BYPASS: cap_val = '0;
            default:  cap_val = {posted, busy ? ACK_WAIT : ACK_OK};
        endcase
    end

    dbg_scan_shreg u_shreg (
        .clk     (clk),
        .rst     (rst),
        .capture (capture_dr),
        .shift   (shift_dr),
        .kind    (kind),
        .cap_val (cap_val),
        .tdi     (tdi),
        .sr      (sr)
    );

    dbg_scan_req u_req (
        .clk         (clk),
        .rst         (rst),
        .kind        (kind),
        .capture     (capture_dr),
        .update      (update_dr),
        .sr          (sr),
        .orun_detect (orun_detect),
        .bus_ack     (bus_ack),
        .bus_err     (bus_err),
        .bus_rdata   (bus_rdata),
        .busy        (busy),
        .req         (req),
        .posted      (posted),
        .abort_pulse (ap_abort),
        .sticky_err  (sticky_err),
        .sticky_orun (sticky_orun)
    );

    assign tdo       = sr[0];
    assign bus_valid = busy;
    assign bus_ap    = req.ap;
    assign bus_write = req.write;
    assign bus_addr  = req.addr;
    assign bus_wdata = req.data;
endmodule

// File: rtl/dbg_scan_port_chk.sv
module dbg_scan_port_chk
    import dbg_scan_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [IR_W-1:0]   ir,
    input logic              capture_dr,
    input logic              update_dr,
    input logic              orun_detect,
    input logic              bus_valid,
    input logic              bus_ap,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack,
    input logic              bus_err,
    input logic              ap_abort,
    input logic              sticky_err,
    input logic              sticky_orun
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!bus_valid && !ap_abort && !sticky_err && !sticky_orun));

    assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ack && !(update_dr && ir == IR_ABORT))
        |=> (bus_valid && $stable(bus_wdata) && $stable(bus_addr) && $stable(bus_ap)));

    assert_launch_after_update_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_valid) |-> $past(update_dr));

    assert_orun_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sticky_orun) |-> ($past(capture_dr) && $past(orun_detect)));

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(sticky_err) |-> $past(bus_valid && bus_ack && bus_err));

    assert_ap_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_valid) && bus_ap) |-> !$past(sticky_err));

    assert_abort_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        ap_abort |=> !ap_abort);

    assert_abort_drops_R9: assert property (@(posedge clk) disable iff (rst)
        ap_abort |-> !bus_valid);
endmodule

bind dbg_scan_port dbg_scan_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ir          (ir),
    .capture_dr  (capture_dr),
    .update_dr   (update_dr),
    .orun_detect (orun_detect),
    .bus_valid   (bus_valid),
    .bus_ap      (bus_ap),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_ack     (bus_ack),
    .bus_err     (bus_err),
    .ap_abort    (ap_abort),
    .sticky_err  (sticky_err),
    .sticky_orun (sticky_orun)
);

// File: tb/dbg_scan_port_bench.sv
module dbg_scan_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ID = 32'h4A5C_3E01;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ir = 4'hF;
    logic        capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic        tdo, orun_detect = 1'b0;
    logic        bus_valid, bus_ap, bus_write;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0, bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        ap_abort, sticky_err, sticky_orun;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;
    logic [35:0] exp_q[$];
    logic prev_valid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_scan_port #(.ID_VALUE(ID)) u_dbg_scan_port (
        .clk(clk), .rst(rst), .ir(ir), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .orun_detect(orun_detect),
        .bus_valid(bus_valid), .bus_ap(bus_ap), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_err(bus_err), .bus_rdata(bus_rdata), .ap_abort(ap_abort),
        .sticky_err(sticky_err), .sticky_orun(sticky_orun)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: every new bus request is compared with the scoreboard head
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_valid && !prev_valid) begin
                if (exp_q.size() == 0) check("R3 unexpected request", {bus_ap, bus_write, bus_addr, bus_wdata}, 36'h0);
                else check("R3 request fields", {bus_ap, bus_write, bus_addr, bus_wdata}, exp_q.pop_front());
            end
            prev_valid <= bus_valid;
        end
    end

    task automatic expect_req(input logic ap, input logic wr, input logic [1:0] a, input logic [31:0] d);
        exp_q.push_back({ap, wr, a, d});
    endtask

    task automatic scan(input logic [3:0] ins, input logic [34:0] din, input int len,
                        output logic [34:0] dout);
        dout = '0;
        @(negedge clk); ir = ins; capture_dr = 1'b1;
        @(negedge clk); capture_dr = 1'b0;
        for (int i = 0; i < len; i++) begin
            dout[i] = tdo; tdi = din[i]; shift_dr = 1'b1;
            @(negedge clk);
        end
        shift_dr = 1'b0; update_dr = 1'b1;
        @(negedge clk); update_dr = 1'b0;
    endtask

    task automatic complete(input logic [31:0] rd, input logic err);
        bus_ack = 1'b1; bus_rdata = rd; bus_err = err;
        @(negedge clk); bus_ack = 1'b0; bus_err = 1'b0;
    endtask

    function automatic logic [34:0] acc(input logic [31:0] d, input logic [1:0] a, input logic rnw);
        return {d, a, rnw};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [34:0] o;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset outputs", {bus_valid, ap_abort, sticky_err, sticky_orun}, 4'b0000);

        // R2 identification register
        scan(4'hE, 35'h0, 32, o);
        check("R2 id value", o[31:0], ID);
        check("R2 no request", bus_valid, 1'b0);

        // R3/R4 debug-port write
        expect_req(1'b0, 1'b1, 2'd1, 32'hCAFE_0001);
        scan(4'hA, acc(32'hCAFE_0001, 2'd1, 1'b0), 35, o);
        check("R4 ack ok", o[2:0], 3'b010);
        repeat (3) @(negedge clk);
        check("R3 held until ack", bus_valid, 1'b1);
        complete(32'h0, 1'b0);
        check("R3 released by ack", bus_valid, 1'b0);

        // R5 posted read
        expect_req(1'b1, 1'b0, 2'd3, 32'h0);
        scan(4'hB, acc(32'h0, 2'd3, 1'b1), 35, o);
        complete(32'h1234_5678, 1'b0);
        expect_req(1'b0, 1'b0, 2'd0, 32'h0);
        scan(4'hA, acc(32'h0, 2'd0, 1'b1), 35, o);
        check("R5 posted data", o[34:3], 32'h1234_5678);
        check("R4 ack ok on read", o[2:0], 3'b010);
        complete(32'hA5A5_0000, 1'b0);

        // R6/R7 WAIT handling
        expect_req(1'b1, 1'b1, 2'd2, 32'h0000_BEEF);
        scan(4'hB, acc(32'h0000_BEEF, 2'd2, 1'b0), 35, o);
        scan(4'hA, acc(32'h0000_DEAD, 2'd1, 1'b0), 35, o);
        check("R4 ack wait", o[2:0], 3'b001);
        check("R5 posted after wait", o[34:3], 32'hA5A5_0000);
        check("R6 data discarded", {bus_valid, bus_ap, bus_addr, bus_wdata}, {1'b1, 1'b1, 2'd2, 32'h0000_BEEF});
        check("R7 no orun when disabled", sticky_orun, 1'b0);
        orun_detect = 1'b1;
        scan(4'hA, acc(32'h0000_DEAD, 2'd1, 1'b0), 35, o);
        check("R7 orun set", sticky_orun, 1'b1);
        orun_detect = 1'b0;
        complete(32'h0, 1'b0);

        // R10 clear overrun
        scan(4'h8, acc(32'h4, 2'd0, 1'b0), 35, o);
        check("R10 orun cleared", sticky_orun, 1'b0);

        // R8 sticky error
        expect_req(1'b0, 1'b1, 2'd1, 32'h0000_0011);
        scan(4'hA, acc(32'h0000_0011, 2'd1, 1'b0), 35, o);
        complete(32'h0, 1'b1);
        check("R8 err set", sticky_err, 1'b1);
        scan(4'hB, acc(32'h0000_0022, 2'd0, 1'b0), 35, o);
        check("R8 ap dropped", bus_valid, 1'b0);
        expect_req(1'b0, 1'b0, 2'd1, 32'h0);
        scan(4'hA, acc(32'h0, 2'd1, 1'b1), 35, o);
        check("R8 dp allowed", bus_valid, 1'b1);
        complete(32'h0, 1'b0);
        scan(4'h8, acc(32'h2, 2'd0, 1'b0), 35, o);
        check("R10 err cleared", sticky_err, 1'b0);

        // R9 abort
        expect_req(1'b1, 1'b0, 2'd0, 32'h0);
        scan(4'hB, acc(32'h0, 2'd0, 1'b1), 35, o);
        scan(4'h8, acc(32'h0, 2'd0, 1'b0), 35, o);
        check("R9 abort bit clear keeps request", {bus_valid, ap_abort}, 2'b10);
        scan(4'h8, acc(32'h1, 2'd0, 1'b0), 35, o);
        check("R9 abort pulse", {bus_valid, ap_abort}, 2'b01);
        @(negedge clk);
        check("R9 pulse one cycle", ap_abort, 1'b0);

        // R11 bypass
        scan(4'h3, 35'h0B2, 8, o);
        check("R11 bypass delay", o[7:0], 8'h64);
        check("R11 no request", bus_valid, 1'b0);

        repeat (2) @(negedge clk);
        check("R3 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule